// File: doc/BRIEF.md
# Programmable-Flag Synchronous FIFO with Fall-Through Option

This block is a single-clock FIFO with one write port and one read port. Depth and data width are parameters, and the depth must be a power of two. It has two timing modes. In standard mode a word is read by asserting the read enable, and the word appears on the output one cycle later. In first-word-fall-through mode the oldest word moves into the output register without any read enable. The read enable then consumes that word, and the next word takes its place.

The mode is sampled from the `fwftSel` input while master reset is held, and it stays fixed until the next master reset. There are two status outputs whose meaning depends on the mode:

- The read-side status is an empty flag in standard mode and an output-ready flag in fall-through mode.
- The write-side status is a full flag in standard mode and an input-ready flag in fall-through mode.

There are three further flags: half-full, almost-empty and almost-full. The almost-empty and almost-full thresholds are two independent offsets. A separate offset-register block supplies them as plain values.

A partial reset empties the FIFO but keeps the latched mode. The offsets are held outside the block, so they are kept as well. The flags are then computed again from the mode and offsets still in force.

Top module: `pflag_fifo`

## Requirements
- R1: While `mrstN` is low at a clock edge, the FIFO becomes empty and `rdData` becomes 0. After master reset with offsets below the depth: `halfN`=1, `almostFullN`=1, `almostEmptyN`=0. After master reset into standard mode: `emptyOrN`=0 and `fullIrN`=1.
- R2: The mode is loaded from `fwftSel` (0 = standard, 1 = fall-through) at each clock edge where `mrstN` is low. A change of `fwftSel` at any other time has no effect.
- R3: In standard mode, `emptyOrN` is 0 exactly when the FIFO holds no words. A read accepted at an edge places the oldest stored word on `rdData` after that same edge.
- R4: In standard mode, `fullIrN` is 0 exactly when the FIFO holds DEPTH words.
- R5: In fall-through mode, a stored word moves into the output register without `rdEn`, one edge after it is written into an otherwise empty FIFO. `emptyOrN` is 0 while the output register holds a valid word. `rdEn` consumes that word, and `emptyOrN` returns to 1 when the last word has been read.
- R6: In fall-through mode, the word count includes the output register. `fullIrN` is 0 while the count is below DEPTH and 1 when the count equals DEPTH.
- R7: A write while the count equals DEPTH is ignored. A read while no word is available is ignored. Neither changes the stored contents.
- R8: `halfN` is 0 exactly when the count exceeds DEPTH/2.
- R9: `almostEmptyN` is 0 exactly when the count is at or below `aeOffset`.
- R10: `almostFullN` is 0 exactly when DEPTH minus the count is at or below `afOffset`.
- R11: While `prstN` is low at an edge (and `mrstN` is high), the FIFO becomes empty and `rdData` becomes 0. The latched mode is kept, and the flags follow the current offsets.
- R12: Words leave the FIFO in the order they were accepted, with their data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| mrstN | input | 1 | Synchronous master reset, active low |
| prstN | input | 1 | Synchronous partial reset, active low |
| fwftSel | input | 1 | Mode select, sampled during master reset |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read enable |
| rdData | output | DATA_W | Read data register |
| aeOffset | input | $clog2(DEPTH)+1 | Almost-empty threshold |
| afOffset | input | $clog2(DEPTH)+1 | Almost-full threshold |
| emptyOrN | output | 1 | Empty flag (standard) / output-ready (fall-through), active low |
| fullIrN | output | 1 | Full flag (standard) / input-ready (fall-through), active low |
| halfN | output | 1 | Half-full flag, active low |
| almostEmptyN | output | 1 | Almost-empty flag, active low |
| almostFullN | output | 1 | Almost-full flag, active low |

## Verification
The bench builds the FIFO with DEPTH=8 and DATA_W=8. With that depth, random traffic biased toward filling or draining reaches both the full and the empty boundary many times in each mode. It also makes overflow and underflow attempts common. Every offset from 0 to DEPTH can be driven, so both threshold edges and the always-on and never-on extremes of the almost flags are exercised. In fall-through mode, the one-word state, where the only word sits in the output register, comes up often. That is the state in which the output-ready and input-ready behaviour is most likely to go wrong.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
  // Strobes issued by the control to the datapath in one cycle.
  typedef struct packed {
    logic clear;  // empty the storage, zero pointers and output
    logic push;   // store wrData at the write pointer
    logic pop;    // move the oldest stored word into rdData
  } fifo_strobe_t;
endpackage

// File: rtl/pflag_fifo_dp.sv
module pflag_fifo_dp
  import pflag_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  fifo_strobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.clear) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop) begin
        rdData <= mem[rdPtr];
        rdPtr  <= rdPtr + 1'b1;
      end
    end
  end

  // R11: a clear strobe returns both pointers to the first location
  a_r11_ptr_clear: assert property (@(posedge clk)
    strobe.clear |=> (wrPtr == '0 && rdPtr == '0 && rdData == '0));

  // R12: an idle cycle leaves the output register untouched
  a_r12_out_hold: assert property (@(posedge clk)
    (!strobe.clear && !strobe.pop) |=> $stable(rdData));
endmodule

// File: rtl/pflag_fifo_ctrl.sv
module pflag_fifo_ctrl
  import pflag_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       mrstN,
  input  logic                       prstN,
  input  logic                       fwftSel,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [$clog2(DEPTH):0]     aeOffset,
  input  logic [$clog2(DEPTH):0]     afOffset,
  output fifo_strobe_t               strobe,
  output logic                       emptyOrN,
  output logic                       fullIrN,
  output logic                       halfN,
  output logic                       almostEmptyN,
  output logic                       almostFullN
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2);

  logic             fwftMode;
  logic             outValid;
  logic [CNT_W-1:0] memCnt;
  logic [CNT_W-1:0] memCntNext;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] freeSpace;
  logic             inReset;
  logic             pushOk;
  logic             popMem;

  assign inReset   = !mrstN || !prstN;
  assign total     = memCnt + {{(CNT_W-1){1'b0}}, outValid};
  assign freeSpace = DEPTH_C - total;
  assign pushOk    = wrEn && (total != DEPTH_C);
  assign popMem    = (memCnt != '0) && (fwftMode ? (!outValid || rdEn) : rdEn);

  always_comb begin
    strobe.clear = inReset;
    strobe.push  = pushOk && !inReset;
    strobe.pop   = popMem && !inReset;
    case ({pushOk, popMem})
      2'b10:   memCntNext = memCnt + 1'b1;
      2'b01:   memCntNext = memCnt - 1'b1;
      default: memCntNext = memCnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      fwftMode <= fwftSel;
      memCnt   <= '0;
      outValid <= 1'b0;
    end else if (!prstN) begin
      memCnt   <= '0;
      outValid <= 1'b0;
    end else begin
      memCnt <= memCntNext;
      if (fwftMode) begin
        if (popMem)     outValid <= 1'b1;
        else if (rdEn)  outValid <= 1'b0;
      end
    end
  end

  always_comb begin
    if (fwftMode) begin
      emptyOrN = !outValid;
      fullIrN  = (total == DEPTH_C);
    end else begin
      emptyOrN = (memCnt != '0);
      fullIrN  = (total != DEPTH_C);
    end
    halfN        = !(total > HALF_C);
    almostEmptyN = !(total <= aeOffset);
    almostFullN  = !(freeSpace <= afOffset);
  end

  // R7: the count never passes the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!mrstN)
    total <= DEPTH_C);

  // R7: a full FIFO with no read stays full, the write is dropped
  a_r7_full_hold: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && total == DEPTH_C && !rdEn) |=> (total == DEPTH_C));

  // R2: mode only changes under master reset
  a_r2_mode_held: assert property (@(posedge clk) disable iff (!mrstN)
    mrstN |=> $stable(fwftMode));

  // R5: in fall-through mode a stored word loads the empty output register
  a_r5_fall_through: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && fwftMode && !outValid && memCnt != '0) |=> outValid);

  // R11: partial reset empties the FIFO
  a_r11_prst_empty: assert property (@(posedge clk) disable iff (!mrstN)
    !prstN |=> (memCnt == '0 && !outValid));
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
  import pflag_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                   clk,
  input  logic                   mrstN,
  input  logic                   prstN,
  input  logic                   fwftSel,
  input  logic                   wrEn,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   rdEn,
  output logic [DATA_W-1:0]      rdData,
  input  logic [$clog2(DEPTH):0] aeOffset,
  input  logic [$clog2(DEPTH):0] afOffset,
  output logic                   emptyOrN,
  output logic                   fullIrN,
  output logic                   halfN,
  output logic                   almostEmptyN,
  output logic                   almostFullN
);
  fifo_strobe_t strobe;

  pflag_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .fwftSel(fwftSel),
    .wrEn(wrEn), .rdEn(rdEn), .aeOffset(aeOffset), .afOffset(afOffset),
    .strobe(strobe), .emptyOrN(emptyOrN), .fullIrN(fullIrN),
    .halfN(halfN), .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  pflag_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/pflag_fifo_tb_top.sv
`timescale 1ns/1ps
module pflag_fifo_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic mrstN = 1'b0, prstN = 1'b1, fwftSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [CNT_W-1:0]  aeOffset = CNT_W'(2), afOffset = CNT_W'(2);
  logic emptyOrN, fullIrN, halfN, almostEmptyN, almostFullN;

  pflag_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .fwftSel(fwftSel),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .aeOffset(aeOffset), .afOffset(afOffset),
    .emptyOrN(emptyOrN), .fullIrN(fullIrN), .halfN(halfN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  int checks = 0;
  int failures = 0;

  // expected-value state built from the requirements
  logic [DATA_W-1:0] mQ[$];
  logic              mMode = 1'b0;
  logic              mOutValid = 1'b0;
  logic [DATA_W-1:0] mOut = '0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mTotal();
    return mQ.size() + int'(mOutValid);
  endfunction

  function automatic logic expEmpty();
    return mMode ? !mOutValid : (mQ.size() != 0);
  endfunction

  function automatic logic expFull();
    return mMode ? (mTotal() == DEPTH) : (mTotal() != DEPTH);
  endfunction

  task automatic checkAll();
    chk(mMode ? "R5 emptyOrN" : "R3 emptyOrN", int'(emptyOrN), int'(expEmpty()));
    chk(mMode ? "R6 fullIrN" : "R4 fullIrN", int'(fullIrN), int'(expFull()));
    chk("R8 halfN", int'(halfN), int'(!(mTotal() > DEPTH / 2)));
    chk("R9 almostEmptyN", int'(almostEmptyN), int'(!(mTotal() <= int'(aeOffset))));
    chk("R10 almostFullN", int'(almostFullN), int'(!((DEPTH - mTotal()) <= int'(afOffset))));
    chk("R12 rdData", int'(rdData), int'(mOut));
  endtask

  // one clock: drive at negedge, update expectations at the edge, compare after
  task automatic cycle(input logic m, input logic p, input logic f,
                       input logic w, input logic [DATA_W-1:0] d, input logic r);
    bit wok, pop;
    mrstN = m; prstN = p; fwftSel = f; wrEn = w; wrData = d; rdEn = r;
    @(posedge clk);
    if (!m || !p) begin
      if (!m) mMode = f;
      mQ.delete();
      mOutValid = 1'b0;
      mOut = '0;
    end else begin
      wok = w && (mTotal() < DEPTH);
      pop = mMode ? (mQ.size() > 0 && (!mOutValid || r)) : (r && mQ.size() > 0);
      if (pop) mOut = mQ.pop_front();
      if (wok) mQ.push_back(d);
      if (mMode) begin
        if (pop) mOutValid = 1'b1;
        else if (r) mOutValid = 1'b0;
      end
    end
    @(negedge clk);
    checkAll();
  endtask

  task automatic randomRun(input int n, input logic f);
    int wp = 50, rp = 50;
    for (int i = 0; i < n; i++) begin
      if (i % 40 == 0) begin
        wp = 20 + int'($urandom % 70);
        rp = 20 + int'($urandom % 70);
        aeOffset = CNT_W'($urandom % (DEPTH + 1));
        afOffset = CNT_W'($urandom % (DEPTH + 1));
      end
      cycle(1'b1, 1'b1, f, int'($urandom % 100) < wp, DATA_W'($urandom),
            int'($urandom % 100) < rp);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R1: master reset into standard mode
    cycle(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    cycle(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    chk("R1 emptyOrN", int'(emptyOrN), 0);
    chk("R1 fullIrN", int'(fullIrN), 1);
    chk("R1 almostEmptyN", int'(almostEmptyN), 0);
    chk("R1 halfN", int'(halfN), 1);
    chk("R1 almostFullN", int'(almostFullN), 1);
    chk("R1 rdData", int'(rdData), 0);

    // R2: fwftSel change outside master reset is ignored: no fall-through
    cycle(1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, 1'b0);
    cycle(1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    cycle(1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    chk("R2 still standard rdData", int'(rdData), 0);
    chk("R2 still standard emptyOrN", int'(emptyOrN), 1);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b1);
    chk("R3 read data", int'(rdData), 'hA5);

    // R7: overfill then overdrain in standard mode
    for (int i = 0; i < DEPTH + 3; i++) cycle(1'b1, 1'b1, 1'b0, 1'b1, DATA_W'(8'h10 + i), 1'b0);
    chk("R4 full at depth", int'(fullIrN), 0);
    for (int i = 0; i < DEPTH + 3; i++) cycle(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b1);
    chk("R7 last kept word", int'(rdData), 'h10 + DEPTH - 1);
    chk("R7 empty after drain", int'(emptyOrN), 0);

    randomRun(600, 1'b0);

    // master reset into fall-through mode
    cycle(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    chk("R5 fell through", int'(rdData), 'h3C);
    chk("R5 output ready", int'(emptyOrN), 0);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b1);
    chk("R5 not ready after last read", int'(emptyOrN), 1);
    for (int i = 0; i < DEPTH + 2; i++) cycle(1'b1, 1'b1, 1'b0, 1'b1, DATA_W'(8'h50 + i), 1'b0);
    chk("R6 input not ready at depth", int'(fullIrN), 1);
    chk("R6 head word", int'(rdData), 'h50);

    // R11: partial reset keeps fall-through mode
    cycle(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    chk("R11 empty after partial reset", int'(emptyOrN), 1);
    chk("R11 input ready", int'(fullIrN), 0);
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 8'h77, 1'b0);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    chk("R11 mode kept", int'(rdData), 'h77);

    randomRun(900, 1'b0);
    // partial reset mid-run with random offsets still in force
    cycle(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    randomRun(300, 1'b1);

    // back to standard mode
    cycle(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    randomRun(600, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule